// File: doc/BRIEF.md
# Prioritized Interrupt and Exception Arbiter

This block sits beside an instruction sequencer. At each instruction boundary it looks at every event that can interrupt the program and picks exactly one of them. The candidates are an internal exception, a single-step trap, a non-maskable interrupt, a coprocessor segment overrun, a maskable external interrupt and a software interrupt instruction.

The block resolves the winner's 8-bit vector type and the address of that type's entry in the vector table. It presents both with a one-cycle take strobe in the cycle after the boundary. The sequencer then does the stack pushes and the vector fetch. Any acknowledge bus cycle is also left to the sequencer.

The non-maskable input is edge-sensitive and is held internally until it is serviced. The maskable input is a level that is looked at only at a boundary and only while the enable flag is set. The other sources are levels that their requesters hold until they are served.

Top module: `irq_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `take` is 0 and `vec_type` and `tbl_addr` are 0. Any pending NMI edge is discarded by reset.
- R2: When several sources are active at one boundary, the block serves the one that comes first in this order: exception, single step, NMI, segment overrun, maskable interrupt (only when it is enabled), software interrupt.
- R3: `exc_code` selects the exception vector type. The codes map as follows: 0 to type 0 (divide), 1 to type 3 (breakpoint), 2 to type 4 (overflow), 3 to type 5 (range check), 4 to type 6 (bad opcode), 5 to type 7 (coprocessor absent), 6 to type 16 (coprocessor error), and 7 to type 6.
- R4: A single-step event of type 1 is raised at a boundary only while `trap_flag` is 1.
- R5: A rising edge on `nmi_in` gives type 2 and stays pending until it is served. Two edges that arrive before service merge into one service. A level held high does not raise the event again.
- R6: `intr` is served at a boundary with type `intr_vec` only when `ie_flag` is 1. When `ie_flag` is 0 it causes no take.
- R7: The software interrupt is served with type `swi_num` for every value from 0 to 255.
- R8: A segment overrun request is served with type 9.
- R9: `tbl_addr` equals the served type times 4, so every entry falls in 0x00000 to 0x003FF.
- R10: `take` goes high only in the cycle right after a cycle in which `boundary` was 1 and some source was active. It lasts exactly one cycle per boundary. Without a boundary, no request causes a take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | Instruction boundary strobe |
| exc_req | input | 1 | Internal exception request |
| exc_code | input | 3 | Exception cause code |
| trap_flag | input | 1 | Single-step trap flag |
| nmi_in | input | 1 | Non-maskable request, edge-sensitive |
| ovr_req | input | 1 | Coprocessor segment overrun request |
| intr | input | 1 | Maskable interrupt request |
| ie_flag | input | 1 | Interrupt enable flag |
| intr_vec | input | 8 | Vector type supplied with the maskable request |
| swi_req | input | 1 | Software interrupt instruction request |
| swi_num | input | 8 | Software interrupt number |
| take | output | 1 | One-cycle service strobe |
| vec_type | output | 8 | Vector type of the served event |
| tbl_addr | output | 20 | Vector table entry address |

## Verification
Every result is due one clock after the boundary cycle. The inputs are sampled on the rising edge where `boundary` is 1, and `take`, `vec_type` and `tbl_addr` are registered on that same edge. The bench therefore drives a boundary at a falling edge and reads the outputs at the next falling edge. It checks one cycle later that `take` has fallen.

An NMI edge is given two full cycles to be latched before any boundary. Any edge that a higher source overrode is drained by an extra boundary, with the expected type 2 computed by the bench.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int VEC_W        = 8,
  parameter int ADDR_W       = 20,
  parameter int CODE_W       = 3,
  parameter int SSTEP_TYPE   = 1,
  parameter int NMI_TYPE     = 2,
  parameter int SEG_OVR_TYPE = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary,
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              trap_flag,
  input  logic              nmi_in,
  input  logic              ovr_req,
  input  logic              intr,
  input  logic              ie_flag,
  input  logic [VEC_W-1:0]  intr_vec,
  input  logic              swi_req,
  input  logic [VEC_W-1:0]  swi_num,
  output logic              take,
  output logic [VEC_W-1:0]  vec_type,
  output logic [ADDR_W-1:0] tbl_addr
);
  localparam int ENTRY_SHIFT = 2;

  logic             nmi_q, nmi_pend;
  logic [VEC_W-1:0] exc_type, sel;

  wire nmi_edge  = nmi_in & ~nmi_q;
  wire nmi_live  = nmi_pend | nmi_edge;
  wire intr_ok   = intr & ie_flag;
  wire any_req   = exc_req | trap_flag | nmi_live | ovr_req | intr_ok | swi_req;
  wire fire      = boundary & any_req;
  wire nmi_taken = fire & ~exc_req & ~trap_flag & nmi_live;

  always_comb begin
    case (exc_code)
      3'd0:    exc_type = VEC_W'(0);
      3'd1:    exc_type = VEC_W'(3);
      3'd2:    exc_type = VEC_W'(4);
      3'd3:    exc_type = VEC_W'(5);
      3'd5:    exc_type = VEC_W'(7);
      3'd6:    exc_type = VEC_W'(16);
      default: exc_type = VEC_W'(6);
    endcase
  end

  always_comb begin
    if (exc_req)        sel = exc_type;
    else if (trap_flag) sel = VEC_W'(SSTEP_TYPE);
    else if (nmi_live)  sel = VEC_W'(NMI_TYPE);
    else if (ovr_req)   sel = VEC_W'(SEG_OVR_TYPE);
    else if (intr_ok)   sel = intr_vec;
    else                sel = swi_num;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
      take     <= 1'b0;
      vec_type <= '0;
      tbl_addr <= '0;
    end else begin
      nmi_q    <= nmi_in;
      nmi_pend <= nmi_live & ~nmi_taken;
      take     <= fire;
      if (fire) begin
        vec_type <= sel;
        tbl_addr <= ADDR_W'(sel) << ENTRY_SHIFT;
      end
    end
  end
endmodule

module irq_arbiter_chk #(
  parameter int VEC_W  = 8,
  parameter int ADDR_W = 20,
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              boundary,
  input logic              exc_req,
  input logic [CODE_W-1:0] exc_code,
  input logic              trap_flag,
  input logic              take,
  input logic [VEC_W-1:0]  vec_type,
  input logic [ADDR_W-1:0] tbl_addr
);
  logic run;
  always_ff @(posedge clk) run <= rst_n;

  // R10
  take_after_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n || !run)
    take |-> $past(boundary));

  // R9
  table_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (tbl_addr == {{(ADDR_W-VEC_W-2){1'b0}}, vec_type, 2'b00}));

  // R2
  exc_wins_chk: assert property (@(posedge clk) disable iff (!rst_n || !run)
    $past(boundary && exc_req) |-> take);

  // R3
  divide_type_chk: assert property (@(posedge clk) disable iff (!rst_n || !run)
    $past(boundary && exc_req && exc_code == 0) |-> (vec_type == 0));

  // R4
  sstep_chk: assert property (@(posedge clk) disable iff (!rst_n || !run)
    $past(boundary && trap_flag && !exc_req) |-> (take && vec_type == 1));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !run |-> (!take && vec_type == 0));
endmodule

bind irq_arbiter irq_arbiter_chk #(.VEC_W(VEC_W), .ADDR_W(ADDR_W), .CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .boundary(boundary), .exc_req(exc_req),
  .exc_code(exc_code), .trap_flag(trap_flag), .take(take),
  .vec_type(vec_type), .tbl_addr(tbl_addr)
);

// File: tb/irq_arbiter_test.sv
module irq_arbiter_test;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0, boundary = 0, exc_req = 0, trap_flag = 0;
  logic nmi_in = 0, ovr_req = 0, intr = 0, ie_flag = 0, swi_req = 0;
  logic [2:0] exc_code = 0;
  logic [7:0] intr_vec = 0, swi_num = 0;
  logic take;
  logic [7:0] vec_type;
  logic [19:0] tbl_addr;
  int errors = 0, checks = 0;
  bit nmi_model = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_arbiter uut (.clk(clk), .rst_n(rst_n), .boundary(boundary), .exc_req(exc_req),
    .exc_code(exc_code), .trap_flag(trap_flag), .nmi_in(nmi_in), .ovr_req(ovr_req),
    .intr(intr), .ie_flag(ie_flag), .intr_vec(intr_vec), .swi_req(swi_req),
    .swi_num(swi_num), .take(take), .vec_type(vec_type), .tbl_addr(tbl_addr));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exc_map(input int c);
    case (c)
      0: return 0; 1: return 3; 2: return 4; 3: return 5;
      5: return 7; 6: return 16; default: return 6;
    endcase
  endfunction

  task automatic clear_in();
    exc_req = 0; trap_flag = 0; ovr_req = 0; intr = 0; ie_flag = 0; swi_req = 0;
  endtask

  task automatic nmi_pulse();
    @(negedge clk) nmi_in = 1;
    @(negedge clk) nmi_in = 0;
    @(negedge clk);
    nmi_model = 1;
  endtask

  // one boundary with current inputs; check result one cycle later
  task automatic bound_chk(input string req, input bit exp_take, input int exp_type);
    @(negedge clk) boundary = 1;
    @(negedge clk) boundary = 0;
    chk({req, " take"}, 32'(take), 32'(exp_take));
    if (exp_take) begin
      chk({req, " type"}, 32'(vec_type), 32'(exp_type));
      chk({"R9 addr for ", req}, 32'(tbl_addr), 32'(exp_type * 4));
    end
    clear_in();
    @(negedge clk);
    chk("R10 pulse width", 32'(take), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 take in reset", 32'(take), 0);
    chk("R1 type in reset", 32'(vec_type), 0);
    nmi_in = 1;
    @(negedge clk) rst_n = 1;
    chk("R1 take after reset", 32'(take), 0);
    chk("R1 addr after reset", 32'(tbl_addr), 0);
    nmi_in = 0;
    @(negedge clk);
    // R1: NMI edge inside reset is not pending
    bound_chk("R1 nmi cleared", 0, 0);

    // R10: requests without boundary
    exc_req = 1; trap_flag = 1; ovr_req = 1; swi_req = 1; intr = 1; ie_flag = 1;
    repeat (4) begin @(negedge clk); chk("R10 no boundary", 32'(take), 0); end
    clear_in();

    // R3
    for (int c = 0; c < 8; c++) begin
      exc_req = 1; exc_code = 3'(c);
      bound_chk("R3 exc", 1, exc_map(c));
    end

    // R7 and R9 sweep
    for (int n = 0; n < 256; n++) begin
      swi_req = 1; swi_num = 8'(n);
      bound_chk("R7 swi", 1, n);
    end

    // R6
    for (int v = 0; v < 256; v += 17) begin
      intr = 1; ie_flag = 1; intr_vec = 8'(v);
      bound_chk("R6 intr enabled", 1, v);
      intr = 1; ie_flag = 0; intr_vec = 8'(v);
      bound_chk("R6 intr masked", 0, 0);
    end

    // R8, R4
    ovr_req = 1; bound_chk("R8 overrun", 1, 9);
    trap_flag = 0; bound_chk("R4 no trap", 0, 0);
    trap_flag = 1; bound_chk("R4 trap", 1, 1);

    // R5
    nmi_pulse(); nmi_pulse();
    bound_chk("R5 merged nmi", 1, 2); nmi_model = 0;
    bound_chk("R5 merged once", 0, 0);
    @(negedge clk) nmi_in = 1;
    repeat (2) @(negedge clk);
    bound_chk("R5 level edge", 1, 2); nmi_model = 0;
    bound_chk("R5 level held", 0, 0);
    @(negedge clk) nmi_in = 0;
    @(negedge clk);

    // R2: all combinations of the six sources
    for (int m = 0; m < 64; m++) begin
      int exp_t;
      bit ie;
      ie = m[6];
      if (m[2]) nmi_pulse();
      exc_req = m[0]; exc_code = 3'(m % 8); trap_flag = m[1];
      ovr_req = m[3]; intr = m[4]; ie_flag = 1; swi_req = m[5];
      intr_vec = 8'(100 + m); swi_num = 8'(200 + m);
      if (m[0]) exp_t = exc_map(m % 8);
      else if (m[1]) exp_t = 1;
      else if (m[2]) exp_t = 2;
      else if (m[3]) exp_t = 9;
      else if (m[4]) exp_t = 100 + m;
      else exp_t = 200 + m;
      if (!m[0] && !m[1] && m[2]) nmi_model = 0;
      bound_chk("R2 priority", m != 0, exp_t);
      if (nmi_model) begin
        bound_chk("R5 drain pending", 1, 2);
        nmi_model = 0;
      end
      if (ie) ;
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule